// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a large set of peripheral transfer-request wires and a bank of DMA channels. A programmable table holds one 8-bit entry per request line. Each entry names a target channel and carries a flag that enables the route. Every request line is sampled on each clock. When a sampled line changes and its entry is enabled, the target channel's stored request level is updated. Depending on the direction of the change and the level the channel held before, the channel also gets a one-cycle "request asserted" pulse or a one-cycle "end of receive" pulse.

Software programs the table through a simple word-addressed register port. Entries are spread over two address windows: a low window for the first 64 lines and a high window for the rest. Downstream channel logic consumes the per-channel level (as its pending flag) and the two event pulses. The channel status register and the transfer engine sit outside this block.

Top module: `dreq_channel_router`

## Requirements
- R1: A map entry is 8 bits. Bit 7 enables the route, bits 4:0 select the target channel, and bits 6:5 are stored and read back unchanged.
- R2: Entry i for i < 64 sits at byte address 0x100 + 4*i. Entry i for 64 <= i < NUM_REQ sits at 0x1100 + 4*(i-64). A write to any other address (unaligned addresses included) changes no entry, and a read from such an address returns 0. Reads are combinational.
- R3: If a mapped request changes from 0 to 1 while its channel's stored level is 0, the channel's request-asserted output pulses high for exactly one cycle. The pulse and the level update appear after the second rising clock edge following the input change.
- R4: If a mapped request changes from 1 to 0 while its channel's stored level is 1, the channel's end-of-receive output pulses high for exactly one cycle, with the same latency as R3.
- R5: The channel's pending output holds the value of the most recent change seen on any request mapped to that channel.
- R6: A request whose entry has bit 7 clear, or whose channel number is NUM_CH or higher, has no effect on any channel output.
- R7: A mapped request changing to the level the channel already holds updates nothing and produces no pulse. A request that holds steady produces no event.
- R8: A write of an enabled entry whose channel number is NUM_CH or higher raises the error output for one cycle after the write, and the entry is still stored.
- R9: Reset clears every map entry to 0 (unmapped) and drives all pending, event and error outputs to 0.
- R10: If several requests mapped to the same channel change in the same cycle, the highest-numbered of them decides the channel update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Map table write strobe |
| reg_addr | input | 16 | Byte address of the map entry |
| reg_wdata | input | 8 | Map entry write data |
| reg_rdata | output | 8 | Map entry read data (combinational) |
| map_err | output | 1 | One-cycle flag: enabled entry written with an out-of-range channel |
| req_in | input | NUM_REQ | Raw peripheral request lines |
| ch_pend | output | NUM_CH | Stored request level per channel |
| ch_ras | output | NUM_CH | One-cycle request-asserted pulse per channel |
| ch_eor | output | NUM_CH | One-cycle end-of-receive pulse per channel |

## Verification
The bench builds the block with the full 75 request lines and only 8 channels. The full line count brings the high address window and its last slot (line 74) within reach. The small channel count leaves channel numbers 8 to 31 encodable but out of range, which exercises both the error flag and the silent-drop path. With only 8 channels, random mappings also collide often, so same-cycle edges from several lines on one channel occur regularly and test the priority rule.

// File: rtl/dreq_route_pkg.sv
package dreq_route_pkg;

    localparam int ADDR_W       = 16;
    localparam int ENTRY_W      = 8;
    localparam int CHAN_FIELD_W = 5;
    localparam int SLOT_IDX_W   = 8;
    localparam int LO_SLOTS     = 64;

    localparam logic [ADDR_W-1:0] LO_WINDOW = 16'h0100;
    localparam logic [ADDR_W-1:0] HI_WINDOW = 16'h1100;

    // Full stored map entry (readback view)
    typedef struct packed {
        logic                    enable;
        logic [1:0]              spare;
        logic [CHAN_FIELD_W-1:0] chan;
    } map_entry_t;

    // Routing view handed to the channel logic
    typedef struct packed {
        logic                    enable;
        logic [CHAN_FIELD_W-1:0] chan;
    } route_t;

    // Result of address decode
    typedef struct packed {
        logic                  hit;
        logic [SLOT_IDX_W-1:0] idx;
    } slot_sel_t;

    // Per-channel registered state
    typedef struct packed {
        logic level;
        logic rise_evt;
        logic fall_evt;
    } chan_state_t;

    function automatic slot_sel_t decode_slot(logic [ADDR_W-1:0] a, int unsigned n_req);
        slot_sel_t s;
        s = '0;
        if (a[1:0] == 2'b00) begin
            if (a[15:8] == LO_WINDOW[15:8]) begin
                s.idx = {2'b00, a[7:2]};
                s.hit = (32'(s.idx) < n_req);
            end else if (a[15:8] == HI_WINDOW[15:8]) begin
                s.idx = SLOT_IDX_W'(LO_SLOTS) + {2'b00, a[7:2]};
                s.hit = (32'(s.idx) < n_req);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/dreq_map_regs.sv
module dreq_map_regs
    import dreq_route_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [ENTRY_W-1:0]    wdata_i,
    output logic [ENTRY_W-1:0]    rdata_o,
    output logic                  err_o,
    output route_t [NUM_REQ-1:0]  route_o
);

    map_entry_t [NUM_REQ-1:0] table_q;
    slot_sel_t                sel;
    map_entry_t               wr_entry;
    logic                     bad_chan;

    assign sel      = decode_slot(addr_i, NUM_REQ);
    assign wr_entry = map_entry_t'(wdata_i);
    assign bad_chan = wr_entry.enable && (32'(wr_entry.chan) >= 32'(NUM_CH));

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
        localparam logic [SLOT_IDX_W-1:0] SLOT_ID = SLOT_IDX_W'(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[i] <= '0;
            end else if (we_i && sel.hit && (sel.idx == SLOT_ID)) begin
                table_q[i] <= wr_entry;
            end
        end

        assign route_o[i].enable = table_q[i].enable;
        assign route_o[i].chan   = table_q[i].chan;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o <= 1'b0;
        end else begin
            err_o <= we_i && sel.hit && bad_chan;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (sel.hit && (sel.idx == SLOT_IDX_W'(i))) begin
                rdata_o = table_q[i];
            end
        end
    end

endmodule

// File: rtl/dreq_edge_sampler.sv
module dreq_edge_sampler #(
    parameter int NUM_REQ = 75
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_REQ-1:0] level_o,
    output logic [NUM_REQ-1:0] toggle_o
);

    logic [NUM_REQ-1:0] cur_q;
    logic [NUM_REQ-1:0] old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            old_q <= '0;
        end else begin
            cur_q <= req_i;
            old_q <= cur_q;
        end
    end

    assign level_o  = cur_q;
    assign toggle_o = cur_q ^ old_q;

endmodule

// File: rtl/dreq_chan_tracker.sv
module dreq_chan_tracker
    import dreq_route_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  route_t [NUM_REQ-1:0]  route_i,
    input  logic   [NUM_REQ-1:0]  level_i,
    input  logic   [NUM_REQ-1:0]  toggle_i,
    output logic   [NUM_CH-1:0]   pend_o,
    output logic   [NUM_CH-1:0]   rise_o,
    output logic   [NUM_CH-1:0]   fall_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [CHAN_FIELD_W-1:0] CH_ID = CHAN_FIELD_W'(c);

        logic        upd;
        logic        new_val;
        chan_state_t st_q;

        // Scan upward so the highest-numbered changing request wins
        always_comb begin
            upd     = 1'b0;
            new_val = 1'b0;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (toggle_i[r] && route_i[r].enable && (route_i[r].chan == CH_ID)) begin
                    upd     = 1'b1;
                    new_val = level_i[r];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= '0;
            end else begin
                st_q.rise_evt <= upd &&  new_val && !st_q.level;
                st_q.fall_evt <= upd && !new_val &&  st_q.level;
                if (upd) begin
                    st_q.level <= new_val;
                end
            end
        end

        assign pend_o[c] = st_q.level;
        assign rise_o[c] = st_q.rise_evt;
        assign fall_o[c] = st_q.fall_evt;
    end

endmodule

// File: rtl/dreq_channel_router.sv
module dreq_channel_router
    import dreq_route_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [15:0]         reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic                map_err,
    input  logic [NUM_REQ-1:0]  req_in,
    output logic [NUM_CH-1:0]   ch_pend,
    output logic [NUM_CH-1:0]   ch_ras,
    output logic [NUM_CH-1:0]   ch_eor
);

    route_t [NUM_REQ-1:0] route;
    logic   [NUM_REQ-1:0] req_level;
    logic   [NUM_REQ-1:0] req_toggle;

    dreq_map_regs #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .err_o   (map_err),
        .route_o (route)
    );

    dreq_edge_sampler #(
        .NUM_REQ (NUM_REQ)
    ) u_smp (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_in),
        .level_o  (req_level),
        .toggle_o (req_toggle)
    );

    dreq_chan_tracker #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) u_trk (
        .clk      (clk),
        .rst      (rst),
        .route_i  (route),
        .level_i  (req_level),
        .toggle_i (req_toggle),
        .pend_o   (ch_pend),
        .rise_o   (ch_ras),
        .fall_o   (ch_eor)
    );

endmodule

// File: rtl/dreq_route_chk.sv
module dreq_route_chk #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic              map_err,
    input logic [NUM_CH-1:0] ch_pend,
    input logic [NUM_CH-1:0] ch_ras,
    input logic [NUM_CH-1:0] ch_eor
);

    a_r8_err_follows_write: assert property (@(posedge clk) disable iff (rst)
        map_err |-> $past(reg_we));

    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ch_pend == '0) && (ch_ras == '0) && (ch_eor == '0) && !map_err);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        a_r3_rise_from_low: assert property (@(posedge clk) disable iff (rst)
            ch_ras[c] |-> ch_pend[c] && !$past(ch_pend[c]));

        a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
            ch_ras[c] |=> !ch_ras[c]);

        a_r4_fall_from_high: assert property (@(posedge clk) disable iff (rst)
            ch_eor[c] |-> !ch_pend[c] && $past(ch_pend[c]));

        a_r5_level_move_has_event: assert property (@(posedge clk) disable iff (rst)
            (ch_pend[c] != $past(ch_pend[c])) |-> (ch_ras[c] || ch_eor[c]));
    end

endmodule

bind dreq_channel_router dreq_route_chk #(
    .NUM_CH (NUM_CH)
) u_route_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_we  (reg_we),
    .map_err (map_err),
    .ch_pend (ch_pend),
    .ch_ras  (ch_ras),
    .ch_eor  (ch_eor)
);

// File: tb/test_dreq_channel_router.sv
module test_dreq_channel_router;

    localparam int NREQ = 75;
    localparam int NCH  = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_we = 1'b0;
    logic [15:0]     reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic            map_err;
    logic [NREQ-1:0] req_in = '0;
    logic [NCH-1:0]  ch_pend, ch_ras, ch_eor;

    int checks = 0;
    int errors = 0;
    bit run_chk = 1'b0;
    bit done = 1'b0;

    // 50 MHz: 20 time-unit period
    always #10 clk = ~clk;

    dreq_channel_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) i_dreq_channel_router (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .map_err(map_err),
        .req_in(req_in), .ch_pend(ch_pend), .ch_ras(ch_ras), .ch_eor(ch_eor)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Address decode per R2, written from the requirement
    function automatic bit slot_of(logic [15:0] a, output int idx);
        idx = 0;
        if (a[1:0] != 0) return 0;
        if (a >= 16'h0100 && a < 16'h0100 + 16'(64 * 4)) begin
            idx = int'(a - 16'h0100) / 4; return 1;
        end
        if (a >= 16'h1100 && a < 16'h1100 + 16'((NREQ - 64) * 4)) begin
            idx = 64 + int'(a - 16'h1100) / 4; return 1;
        end
        return 0;
    endfunction

    function automatic logic [15:0] addr_of(int i);
        return (i < 64) ? 16'(16'h0100 + 4 * i) : 16'(16'h1100 + 4 * (i - 64));
    endfunction

    // Reference model state
    bit [7:0]      mmap [NREQ];
    bit [NREQ-1:0] ms, mp;
    bit [NCH-1:0]  mlvl, mras, meor;
    bit            merr;

    always @(posedge clk) begin : mdl
        bit [NCH-1:0] nl, nr, ne;
        int w, idx;
        bit hit;
        if (rst) begin
            for (int i = 0; i < NREQ; i++) mmap[i] <= '0;
            ms <= '0; mp <= '0; mlvl <= '0; mras <= '0; meor <= '0; merr <= 1'b0;
        end else begin
            nl = mlvl; nr = '0; ne = '0;
            for (int ch = 0; ch < NCH; ch++) begin
                w = -1;
                for (int r = 0; r < NREQ; r++)
                    if ((ms[r] ^ mp[r]) && mmap[r][7] && (int'(mmap[r][4:0]) == ch)) w = r;
                if (w >= 0) begin
                    nr[ch] = ms[w] && !mlvl[ch];
                    ne[ch] = !ms[w] && mlvl[ch];
                    nl[ch] = ms[w];
                end
            end
            mlvl <= nl; mras <= nr; meor <= ne;
            ms <= req_in; mp <= ms;
            hit = slot_of(reg_addr, idx);
            merr <= reg_we && hit && reg_wdata[7] && (int'(reg_wdata[4:0]) >= NCH);
            if (reg_we && hit) mmap[idx] <= reg_wdata;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && run_chk) begin
            chk(ch_pend == mlvl, "R5 pend", 32'(ch_pend), 32'(mlvl));
            chk(ch_ras == mras, "R3 ras", 32'(ch_ras), 32'(mras));
            chk(ch_eor == meor, "R4 eor", 32'(ch_eor), 32'(meor));
            chk(map_err == merr, "R8 err", 32'(map_err), 32'(merr));
        end
    end

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(logic [15:0] a, logic [7:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        settle(3);
        // R9: reset state
        chk(ch_pend == 0 && ch_ras == 0 && ch_eor == 0, "R9 outputs in reset",
            32'({ch_pend, ch_ras, ch_eor}), 0);
        rst = 1'b0;
        settle(1);
        chk(map_err == 0, "R9 err after reset", 32'(map_err), 0);
        rd_chk(16'h0100, 8'h00, "R9 entry0 cleared");
        rd_chk(16'h1128, 8'h00, "R9 entry74 cleared");
        run_chk = 1'b1;

        // R1/R2: format and both windows
        wr(16'h010C, 8'h82);
        rd_chk(16'h010C, 8'h82, "R1 entry3 readback");
        wr(16'h1128, 8'hE5);
        rd_chk(16'h1128, 8'hE5, "R1 spare bits kept entry74");
        wr(16'h1100, 8'h81);
        rd_chk(16'h1100, 8'h81, "R2 entry64 high window");
        wr(16'h112C, 8'hFF);
        rd_chk(16'h112C, 8'h00, "R2 past last slot");
        wr(16'h0102, 8'h83);
        rd_chk(16'h0100, 8'h00, "R2 unaligned write ignored");
        rd_chk(16'h0104, 8'h00, "R2 unaligned neighbour untouched");

        // R8: out-of-range channel flagged and stored
        wr(16'h0114, 8'h8C);
        chk(map_err == 1'b1, "R8 err pulse", 32'(map_err), 1);
        rd_chk(16'h0114, 8'h8C, "R8 entry still stored");
        settle(1);
        chk(map_err == 1'b0, "R8 err one cycle", 32'(map_err), 0);

        // R3: rise with latency
        req_in[3] = 1'b1;
        settle(1);
        chk(ch_ras == 0, "R3 not before second edge", 32'(ch_ras), 0);
        settle(1);
        chk(ch_ras == 8'h04, "R3 ras ch2", 32'(ch_ras), 32'h04);
        settle(1);
        chk(ch_ras == 0 && ch_pend == 8'h04, "R3 pulse ends, R5 pend", 32'({ch_ras, ch_pend}), 32'h0004);

        // R6: unmapped line and out-of-range channel
        req_in[7] = 1'b1; req_in[5] = 1'b1;
        settle(3);
        chk(ch_ras == 0 && ch_pend == 8'h04, "R6 no effect", 32'({ch_ras, ch_pend}), 32'h0004);

        // R7: same-level change, then R4
        wr(16'h0128, 8'h82);
        req_in[10] = 1'b1;
        settle(2);
        chk(ch_ras == 0 && ch_pend == 8'h04, "R7 no ras when high", 32'({ch_ras, ch_pend}), 32'h0004);
        req_in[3] = 1'b0;
        settle(2);
        chk(ch_eor == 8'h04 && ch_pend == 0, "R4 eor ch2", 32'({ch_eor, ch_pend}), 32'h0400);
        req_in[10] = 1'b0;
        settle(2);
        chk(ch_eor == 0, "R7 no eor when low", 32'(ch_eor), 0);

        // R10: same-cycle priority
        wr(16'h0150, 8'h81);
        wr(16'h1118, 8'h81);
        req_in[20] = 1'b1;
        settle(3);
        req_in[20] = 1'b0; req_in[70] = 1'b1;
        settle(2);
        chk(ch_eor[1] == 0 && ch_pend[1] == 1, "R10 high index wins rise", 32'({ch_eor[1], ch_pend[1]}), 32'b01);
        req_in[20] = 1'b1; req_in[70] = 1'b0;
        settle(2);
        chk(ch_eor[1] == 1 && ch_pend[1] == 0, "R10 high index wins fall", 32'({ch_eor[1], ch_pend[1]}), 32'b10);

        // Random phase, compared each cycle by the model (R3 R4 R5 R6 R8 R10)
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            reg_we = 1'b0;
            if ($urandom_range(15) == 0) begin
                reg_we = 1'b1;
                reg_addr = ($urandom_range(19) == 0) ? 16'($urandom) : addr_of($urandom_range(NREQ - 1));
                reg_wdata = {($urandom_range(3) != 0), 2'($urandom), 5'($urandom_range(11))};
            end
            for (int r = 0; r < NREQ; r++)
                if ($urandom_range(23) == 0) req_in[r] = ~req_in[r];
        end
        @(negedge clk);
        reg_we = 1'b0;
        settle(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule